// File: doc/BRIEF.md
# Training-Word Lane Skew Aligner

This block lines up a group of deserialized source-synchronous lanes against each other: sixteen data lanes and one control lane. An external deserializer hands over one parallel word per lane every cycle and can shift any lane by one bit position when asked. The aligner takes these words, the deserializer's lock flag and a force-unlock request. It returns a one-hot vector of single-cycle bit-slip pulses, a sticky error flag per lane, and one status flag that goes high once every lane shows the link training word.

The lanes are handled one after another, starting at lane 0. The current lane is sampled until its word equals the training word on two samples in a row. When a sample misses, the lane gets one slip pulse, and the block then waits a fixed settle time before it samples that lane again. A lane that has not matched after as many slips as there are bits in a word is flagged, and the search moves on to the next lane. The procedure runs once after reset. It runs again only after the force-unlock request has been raised and then dropped.

The lane words arrive on every clock cycle with no valid/ready handshake. The deserializer cannot be paused, so the block applies no back-pressure and consumes the selected lane's word in every cycle in which it is sampling. The control pins and status pins are plain levels.

Top module: `tp_lane_aligner`

## Requirements
- R1: The block serves NUM_LANES=17 lanes. The word of lane i is bits [i*WORD_W +: WORD_W] of `lane_words_i`, and lane 16 is the control lane. Bit i of `slip_o` and bit i of `lane_err_o` belong to lane i.
- R2: A slip request is a one-cycle pulse on at most one bit of `slip_o`. After a pulse, no further pulse follows for SETTLE_CYC (4) cycles. In each slip-and-settle round the lane uses 1+SETTLE_CYC cycles.
- R3: Alignment starts only when `force_unlock_i` is low and `lock_i` is high. No slip pulse is issued in the cycle after any cycle in which `lock_i` is low.
- R4: Lanes are handled in order from lane 0 up to lane 16. A lane is finished after two consecutive samples equal to TRAIN_WORD (8'h0F), and the next lane is sampled in the cycle after that. A lane whose word needs s slips takes s*(1+SETTLE_CYC)+2 cycles and gets exactly s pulses.
- R5: A lane that has had WORD_W slips and still mismatches sets its bit in `lane_err_o` and the search moves on. Such a lane takes WORD_W*(1+SETTLE_CYC)+1 cycles. In each cycle at most one error bit newly rises.
- R6: If `lock_i` drops while alignment is in progress, the block returns to waiting. When the lock flag returns, the procedure restarts from lane 0.
- R7: `aligned_o` rises only when all lanes have finished with no error flag. It then stays high, whatever `lock_i` does, until `force_unlock_i` is raised. While it is high, no slips are issued.
- R8: Raising `force_unlock_i` drops `aligned_o` in the next cycle. When the request is released, the procedure runs again from lane 0 and clears every error flag first.
- R9: While the reset is asserted and after it is released, `slip_o`, `lane_err_o` and `aligned_o` are zero until alignment starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the parallel words |
| rst_ni | input | 1 | Active-low synchronous reset |
| lane_words_i | input | NUM_LANES*WORD_W | Parallel word of every lane, lane i at bits [i*WORD_W +: WORD_W] |
| lock_i | input | 1 | Deserializer lock flag |
| force_unlock_i | input | 1 | Request to drop alignment and run it again once released |
| slip_o | output | NUM_LANES | One-hot bit-slip pulses, one bit per lane |
| lane_err_o | output | NUM_LANES | Sticky flag per lane: training word never found |
| aligned_o | output | 1 | All lanes aligned with no error |

## Verification
The bench models each lane as the training word rotated by a per-lane offset that every slip pulse advances. It sweeps eight offset sets in which every lane takes every offset from 0 to 7. Comparing each lane's pulse count and the total time to `aligned_o` against the per-lane cost formula shows whether the lane order, the settle wait and the two-sample confirmation are right. Lanes stuck at a word that can never match check the give-up count and the error mask. A lock drop in the middle of a run tells a restart from lane 0 apart from a resume. Toggling the lock flag after alignment, and raising force-unlock, check that the status is held and then released.

// File: rtl/tp_align_pkg.sv
package tp_align_pkg;

  typedef enum logic [1:0] {
    ST_WAIT   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } align_st_e;

endpackage

// File: rtl/tp_lane_pick.sv
module tp_lane_pick #(
  parameter int NUM_LANES = 17,
  parameter int WORD_W    = 8,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_LANES*WORD_W-1:0] lanes_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [WORD_W-1:0]           word_o
);

  logic [WORD_W-1:0] lane_arr [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_unpack
    assign lane_arr[g] = lanes_i[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (idx_i == IDX_W'(i)) word_o = lane_arr[i];
    end
  end

endmodule

// File: rtl/tp_slip_driver.sv
module tp_slip_driver #(
  parameter int NUM_LANES = 17,
  parameter int IDX_W     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LANES-1:0] slip_o
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_pulse
    always_ff @(posedge clk_i) begin
      if (!rst_ni) slip_o[g] <= 1'b0;
      else         slip_o[g] <= fire_i && (idx_i == IDX_W'(g));
    end
  end

endmodule

// File: rtl/tp_lane_flags.sv
module tp_lane_flags #(
  parameter int NUM_LANES = 17,
  parameter int IDX_W     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 set_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [NUM_LANES-1:0] err_o
);

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_flag
    always_ff @(posedge clk_i) begin
      if (!rst_ni)                                err_o[g] <= 1'b0;
      else if (clr_i)                             err_o[g] <= 1'b0;
      else if (set_i && (idx_i == IDX_W'(g)))     err_o[g] <= 1'b1;
    end
  end

endmodule

// File: rtl/tp_lane_aligner.sv
module tp_lane_aligner
  import tp_align_pkg::*;
#(
  parameter int              NUM_LANES  = 17,
  parameter int              WORD_W     = 8,
  parameter int              SETTLE_CYC = 4,
  parameter logic [WORD_W-1:0] TRAIN_WORD = 8'h0F
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LANES*WORD_W-1:0] lane_words_i,
  input  logic                        lock_i,
  input  logic                        force_unlock_i,
  output logic [NUM_LANES-1:0]        slip_o,
  output logic [NUM_LANES-1:0]        lane_err_o,
  output logic                        aligned_o
);

  localparam int IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int SLIP_W   = $clog2(WORD_W + 1);
  localparam int SETTLE_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [IDX_W-1:0]    LAST_LANE = IDX_W'(NUM_LANES - 1);
  localparam logic [SLIP_W-1:0]   SLIP_MAX  = SLIP_W'(WORD_W);
  localparam logic [SETTLE_W-1:0] SETTLE_LD = SETTLE_W'(SETTLE_CYC - 1);

  align_st_e            st_q;
  logic [IDX_W-1:0]     lane_q;
  logic [SLIP_W-1:0]    slips_q;
  logic [SETTLE_W-1:0]  settle_q;
  logic                 seen_q;

  logic [WORD_W-1:0]    cur_word;
  logic                 hit;
  logic                 abort;
  logic                 sampling;
  logic                 fire;
  logic                 give_up;
  logic                 advance;
  logic                 start;

  tp_lane_pick #(
    .NUM_LANES (NUM_LANES),
    .WORD_W    (WORD_W),
    .IDX_W     (IDX_W)
  ) u_pick (
    .lanes_i (lane_words_i),
    .idx_i   (lane_q),
    .word_o  (cur_word)
  );

  // Control decode for the sampling state.
  assign hit      = (cur_word == TRAIN_WORD);
  assign abort    = force_unlock_i || !lock_i;
  assign start    = (st_q == ST_WAIT) && !abort;
  assign sampling = (st_q == ST_CHECK) && !abort;
  assign fire     = sampling && !hit && (slips_q != SLIP_MAX);
  assign give_up  = sampling && !hit && (slips_q == SLIP_MAX);
  assign advance  = give_up || (sampling && hit && seen_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      st_q     <= ST_WAIT;
      lane_q   <= '0;
      slips_q  <= '0;
      settle_q <= '0;
      seen_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (start) begin
            st_q    <= ST_CHECK;
            lane_q  <= '0;
            slips_q <= '0;
            seen_q  <= 1'b0;
          end
        end
        ST_CHECK: begin
          if (abort) begin
            st_q    <= ST_WAIT;
            lane_q  <= '0;
            slips_q <= '0;
            seen_q  <= 1'b0;
          end else if (advance) begin
            seen_q  <= 1'b0;
            slips_q <= '0;
            if (lane_q == LAST_LANE) st_q   <= ST_DONE;
            else                     lane_q <= lane_q + 1'b1;
          end else if (hit) begin
            seen_q <= 1'b1;
          end else begin
            seen_q   <= 1'b0;
            slips_q  <= slips_q + 1'b1;
            settle_q <= SETTLE_LD;
            st_q     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (abort) begin
            st_q    <= ST_WAIT;
            lane_q  <= '0;
            slips_q <= '0;
            seen_q  <= 1'b0;
          end else if (settle_q == '0) begin
            st_q <= ST_CHECK;
          end else begin
            settle_q <= settle_q - 1'b1;
          end
        end
        ST_DONE: begin
          if (force_unlock_i) begin
            st_q   <= ST_WAIT;
            lane_q <= '0;
          end
        end
        default: st_q <= ST_WAIT;
      endcase
    end
  end

  tp_slip_driver #(
    .NUM_LANES (NUM_LANES),
    .IDX_W     (IDX_W)
  ) u_slip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .idx_i  (lane_q),
    .slip_o (slip_o)
  );

  tp_lane_flags #(
    .NUM_LANES (NUM_LANES),
    .IDX_W     (IDX_W)
  ) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .set_i  (give_up),
    .idx_i  (lane_q),
    .err_o  (lane_err_o)
  );

  assign aligned_o = (st_q == ST_DONE) && (lane_err_o == '0);

endmodule

// File: rtl/tp_lane_aligner_chk.sv
module tp_lane_aligner_chk #(
  parameter int NUM_LANES = 17
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 lock_i,
  input logic                 force_unlock_i,
  input logic [NUM_LANES-1:0] slip_o,
  input logic [NUM_LANES-1:0] lane_err_o,
  input logic                 aligned_o
);

  a_r2_slip_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slip_o));

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_o != '0) |=> (slip_o == '0));

  a_r3_no_slip_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> (slip_o == '0));

  a_r5_one_new_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_err_o & ~$past(lane_err_o)));

  a_r7_aligned_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned_o && !force_unlock_i) |=> aligned_o);

  a_r7_quiet_when_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |=> (slip_o == '0));

  a_r8_force_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_unlock_i |=> !aligned_o);

endmodule

bind tp_lane_aligner tp_lane_aligner_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lock_i         (lock_i),
  .force_unlock_i (force_unlock_i),
  .slip_o         (slip_o),
  .lane_err_o     (lane_err_o),
  .aligned_o      (aligned_o)
);

// File: tb/tb_tp_lane_aligner.sv
`timescale 1ns/1ps
module tb_tp_lane_aligner;

  localparam int NL = 17;
  localparam int D  = 8;
  localparam int S  = 4;
  localparam logic [D-1:0] TW = 8'h0F;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NL*D-1:0]   lane_words_i;
  logic              lock_i = 1'b0;
  logic              force_unlock_i = 1'b0;
  logic [NL-1:0]     slip_o;
  logic [NL-1:0]     lane_err_o;
  logic              aligned_o;

  int errors = 0;
  int checks = 0;

  // Lane model: word = training word rotated by off[i]; each slip advances off[i].
  int      off [NL];
  int      cnt [NL];
  bit      stuck [NL];
  int      ld_off [NL];
  bit      ld_req = 1'b0;

  always #4 clk_i = ~clk_i;

  tp_lane_aligner #(
    .NUM_LANES (NL), .WORD_W (D), .SETTLE_CYC (S), .TRAIN_WORD (TW)
  ) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .lane_words_i (lane_words_i),
    .lock_i (lock_i), .force_unlock_i (force_unlock_i),
    .slip_o (slip_o), .lane_err_o (lane_err_o), .aligned_o (aligned_o)
  );

  function automatic logic [D-1:0] rotl(input logic [D-1:0] w, input int n);
    logic [D-1:0] r = w;
    for (int k = 0; k < n; k++) r = {r[D-2:0], r[D-1]};
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NL; i++)
      lane_words_i[i*D +: D] = stuck[i] ? '0 : rotl(TW, off[i]);
  end

  always @(posedge clk_i) begin
    for (int i = 0; i < NL; i++) begin
      if (ld_req) begin
        off[i] <= ld_off[i];
        cnt[i] <= 0;
      end else if (slip_o[i]) begin
        off[i] <= (off[i] + 1) % D;
        cnt[i] <= cnt[i] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int need(input int o);
    return (D - o) % D;
  endfunction

  // Expected cycles from start to done, from the per-lane cost rules (R4, R5).
  function automatic int exp_time();
    int t = 0;
    for (int i = 0; i < NL; i++)
      t += stuck[i] ? D*(1+S)+1 : need(off[i])*(1+S)+2;
    return t;
  endfunction

  task automatic load(input int base, input int step);
    @(negedge clk_i);
    for (int i = 0; i < NL; i++) ld_off[i] = (base + i*step) % D;
    ld_req = 1'b1;
    @(negedge clk_i);
    ld_req = 1'b0;
  endtask

  // Counts edges until aligned_o is high; limit counts as a failed check.
  task automatic wait_aligned(input int limit, output int n);
    n = 0;
    while (1) begin
      @(posedge clk_i); n++;
      #1;
      if (aligned_o) break;
      if (n >= limit) begin
        chk(0, "R7", "watchdog waiting for aligned", n, limit);
        break;
      end
    end
  endtask

  task automatic check_counts(input string req);
    for (int i = 0; i < NL; i++) begin
      int e = stuck[i] ? D : need(ld_off[i]);
      chk(cnt[i] == e, req, $sformatf("slips on lane %0d", i), cnt[i], e);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n, t, snap;
    for (int i = 0; i < NL; i++) begin
      stuck[i] = 0; ld_off[i] = 0;
    end
    ld_req = 1'b1;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk(slip_o == '0, "R9", "slip_o in reset", int'(slip_o), 0);
    chk(aligned_o == 1'b0, "R9", "aligned_o in reset", aligned_o, 0);
    ld_req = 1'b0;
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(lane_err_o == '0, "R9", "lane_err_o after reset", int'(lane_err_o), 0);
    chk(slip_o == '0 && !aligned_o, "R3", "idle without lock", int'(slip_o), 0);

    // First run: offsets (i*3)%8, started by lock rising (R3, R4, R1).
    load(0, 3);
    t = exp_time();
    lock_i = 1'b1;
    wait_aligned(5000, n);
    chk(n == t + 1, "R4", "cycles to aligned, first run", n, t + 1);
    check_counts("R1");
    chk(lane_err_o == '0, "R7", "no errors when aligned", int'(lane_err_o), 0);

    // R7: lock toggling after alignment has no effect.
    @(negedge clk_i); lock_i = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(aligned_o == 1'b1, "R7", "aligned held with lock low", aligned_o, 1);
    lock_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk(aligned_o == 1'b1, "R7", "aligned held after lock returns", aligned_o, 1);
    chk(cnt[0] == need(ld_off[0]), "R7", "no new slips while aligned", cnt[0], need(ld_off[0]));

    // R8: force unlock, then rerun with all lanes already aligned.
    force_unlock_i = 1'b1;
    @(negedge clk_i);
    chk(aligned_o == 1'b0, "R8", "aligned dropped by force", aligned_o, 0);
    load(0, 0);
    t = exp_time();
    force_unlock_i = 1'b0;
    wait_aligned(5000, n);
    chk(n == t + 1, "R8", "rerun time on aligned lanes", n, t + 1);

    // Sweep: every lane sees every offset across eight sets (R2, R4).
    for (int k = 0; k < D; k++) begin
      @(negedge clk_i); force_unlock_i = 1'b1;
      load(k, 1);
      t = exp_time();
      force_unlock_i = 1'b0;
      wait_aligned(5000, n);
      chk(n == t + 1, "R2", $sformatf("sweep %0d cycles", k), n, t + 1);
      check_counts("R4");
    end

    // R5: lanes 3 and 16 never show the training word.
    @(negedge clk_i); force_unlock_i = 1'b1;
    stuck[3] = 1; stuck[16] = 1;
    load(5, 3);
    t = exp_time();
    force_unlock_i = 1'b0;
    repeat (t + 1) @(posedge clk_i);
    #1;
    chk(lane_err_o == ((NL'(1) << 16) | (NL'(1) << 3)), "R5", "error mask",
        int'(lane_err_o), (1 << 16) | (1 << 3));
    chk(aligned_o == 1'b0, "R7", "not aligned with errors", aligned_o, 0);
    check_counts("R5");
    repeat (10) @(negedge clk_i);
    chk(cnt[3] == D, "R5", "no slips after giving up", cnt[3], D);

    // R8: a rerun clears the error flags once the lanes can match again.
    force_unlock_i = 1'b1;
    @(negedge clk_i);
    stuck[3] = 0; stuck[16] = 0;
    load(2, 5);
    force_unlock_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(lane_err_o == '0, "R8", "errors cleared on restart", int'(lane_err_o), 0);
    wait_aligned(5000, n);
    check_counts("R8");

    // R6: lock drop mid-run, then restart from lane 0.
    @(negedge clk_i); force_unlock_i = 1'b1;
    load(1, 1);
    force_unlock_i = 1'b0;
    repeat (40) @(negedge clk_i);
    lock_i = 1'b0;
    @(negedge clk_i);
    snap = 0;
    for (int i = 0; i < NL; i++) snap += cnt[i];
    repeat (8) @(negedge clk_i);
    t = 0;
    for (int i = 0; i < NL; i++) t += cnt[i];
    chk(t == snap, "R3", "no slips while lock low", t, snap);
    chk(aligned_o == 1'b0, "R6", "not aligned after lock loss", aligned_o, 0);
    t = exp_time();
    lock_i = 1'b1;
    wait_aligned(5000, n);
    chk(n == t + 1, "R6", "restart time from lane 0", n, t + 1);
    check_counts("R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule